// File: doc/BRIEF.md
# DDR Write Burst Data Capture

This block is the write data path on the device side of a double-data-rate memory model. Write commands carry a bank, a starting pair column and an auto-precharge flag. They are accepted on a sampling clock, but only in the sample marked as a memory-clock rising edge. The data strobe is an ordinary sampled input. A change in its sampled level is a capture edge. The first beat of a burst is taken on the first rising edge after its command, and each later beat on the next edge, alternating rising and falling.

Beats are grouped into pairs: an even-column byte followed by an odd-column byte. Each pair is committed to a small byte-lane array in one write, and a per-beat mask removes single bytes. A write issued while earlier bursts are still outstanding is queued behind them. When the newer command arrives x memory cycles after the previous one, the previous burst is cut to x pairs, so the data stream continues with no gap. A burst with the precharge flag set reports its bank once its last pair is written. A registered debug port reads back the array one pair word at a time.

Top module: `ddr_wr_capture`

## Requirements
- R1: `bl_sel` selects the burst length: 0 gives 2 beats (1 pair), 1 gives 4 beats (2 pairs), and 2 or 3 give 8 beats (4 pairs).
- R2: The first beat of a burst is captured in the first sample where `dqs` rises after the command was accepted. Later beats are captured at each following change of `dqs`. Capture is correct for first-edge delays of 3, 4 and 5 samples, which are 0.75, 1.0 and 1.25 memory cycles when `ck_rise` pulses every 4 samples.
- R3: Beat 2p of a burst goes to the even column and beat 2p+1 to the odd column of one pair word, and both are written together. In a pair word, bits [7:0] hold the even column and bits [15:8] the odd column.
- R4: `cmd_pcol` is the starting column divided by two. Pair p of a burst goes to pair column (start & ~(P-1)) | ((start + p) & (P-1)), where P is the number of pairs per burst, so the burst wraps inside its aligned block.
- R5: A beat captured with `dm` high leaves its byte unchanged, while the other byte of the same pair is still written.
- R6: A write accepted x memory cycles after the previous accepted write cuts that earlier burst to min(x, P) pairs. The new burst's data then follows on the next strobe edges.
- R7: Strobe edges and data that arrive while no burst is outstanding change nothing in the array.
- R8: When the last pair of a burst that has the precharge flag set is written, `pre_valid` goes high for exactly one clock with `pre_bank` equal to the burst's bank. A burst without the flag gives no pulse.
- R9: After reset, `pre_valid` is 0, no burst is outstanding and `dbg_data` is 0. The array powers up all zero.
- R10: A command is accepted only when `cmd_wr` and `ck_rise` are both high. Up to DEPTH bursts, 4 by default, can be outstanding at once.
- R11: `dbg_data` shows the pair word addressed by `dbg_addr = {bank, pair column}` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ck_rise | input | 1 | Marks the sample holding a memory-clock rising edge |
| cmd_wr | input | 1 | Write command request |
| cmd_bank | input | 2 | Command bank |
| cmd_pcol | input | 3 | Command starting pair column |
| cmd_ap | input | 1 | Auto-precharge flag of the command |
| bl_sel | input | 2 | Static burst length select |
| dqs | input | 1 | Sampled data strobe |
| dq | input | 8 | Data beat |
| dm | input | 1 | Mask for the current beat, high means do not write |
| dbg_addr | input | 5 | Debug read address {bank, pair column} |
| dbg_data | output | 16 | Registered debug read data |
| pre_valid | output | 1 | Single-clock pulse when a flagged burst completes |
| pre_bank | output | 2 | Bank of the completed flagged burst |

## Verification
The hardest state to reach is a queue holding several outstanding bursts while a new command shortens the newest of them. Truncation is decided by command spacing, but it only shows up once the strobe stream reaches the entries later. The stimulus schedules commands 1, 2 and 3 memory cycles apart at first-edge delays of 3 and 5 samples. It lays each burst's beats end to end in a precomputed strobe timeline, so the strobe runs without gaps across the shortened bursts. Stray strobe activity and a command request outside a memory-clock edge follow a finished burst, to show that neither reaches the array.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  // Number of data pairs per burst for a burst-length select code.
  function automatic int unsigned pairs_of(logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/ddrw_strobe_capture.sv
module ddrw_strobe_capture #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dqs,
  input  logic [DW-1:0]   dq,
  input  logic            dm,
  input  logic            active,
  output logic            pair_v,
  output logic [2*DW-1:0] pair_data,
  output logic [1:0]      pair_keep
);

  logic          dqs_q;
  logic          have_lo;
  logic [DW-1:0] lo_data;
  logic          lo_keep;
  logic          rise, fall;

  assign rise = dqs & ~dqs_q;
  assign fall = ~dqs & dqs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dqs_q     <= 1'b0;
      have_lo   <= 1'b0;
      lo_data   <= '0;
      lo_keep   <= 1'b0;
      pair_v    <= 1'b0;
      pair_data <= '0;
      pair_keep <= '0;
    end else begin
      dqs_q  <= dqs;
      pair_v <= 1'b0;
      if (rise && active) begin
        lo_data <= dq;
        lo_keep <= ~dm;
        have_lo <= 1'b1;
      end else if (fall && have_lo) begin
        pair_v    <= 1'b1;
        pair_data <= {dq, lo_data};
        pair_keep <= {~dm, lo_keep};
        have_lo   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddrw_cmd_queue.sv
module ddrw_cmd_queue
  import ddrw_pkg::*;
#(
  parameter int BW    = 2,
  parameter int PW    = 3,
  parameter int DEPTH = 4,
  parameter int MAXP  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ck_rise,
  input  logic                         cmd_wr,
  input  logic [BW-1:0]                cmd_bank,
  input  logic [PW-1:0]                cmd_pcol,
  input  logic                         cmd_ap,
  input  logic [1:0]                   bl_sel,
  input  logic                         pair_v,
  output logic                         active,
  output logic [BW+PW-1:0]             waddr,
  output logic [$clog2(DEPTH+1)-1:0]   q_cnt,
  output logic                         pre_valid,
  output logic [BW-1:0]                pre_bank
);

  localparam int LW   = $clog2(MAXP + 1);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BW-1:0] q_bank [DEPTH];
  logic [PW-1:0] q_pcol [DEPTH];
  logic          q_ap   [DEPTH];
  logic [LW-1:0] q_lim  [DEPTH];
  logic [BW-1:0] n_bank [DEPTH];
  logic [PW-1:0] n_pcol [DEPTH];
  logic          n_ap   [DEPTH];
  logic [LW-1:0] n_lim  [DEPTH];
  logic [CNTW-1:0] n_cnt;
  logic [LW-1:0] pidx, elapsed, maxp, newlim;
  logic [PW-1:0] mskp;
  logic          push, pop;

  assign maxp   = LW'(pairs_of(bl_sel));
  assign mskp   = PW'(maxp - LW'(1));
  assign push   = ck_rise & cmd_wr;
  assign newlim = ((elapsed + LW'(1)) >= maxp) ? maxp : (elapsed + LW'(1));
  assign active = (q_cnt != '0);
  assign waddr  = {q_bank[0], (q_pcol[0] & ~mskp) | ((q_pcol[0] + PW'(pidx)) & mskp)};

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      n_bank[i] = q_bank[i];
      n_pcol[i] = q_pcol[i];
      n_ap[i]   = q_ap[i];
      n_lim[i]  = q_lim[i];
    end
    n_cnt = q_cnt;
    pop   = 1'b0;
    // newest outstanding burst is shortened by the spacing to this command
    if (push && q_cnt != '0) begin
      if (newlim < n_lim[IW'(q_cnt - CNTW'(1))])
        n_lim[IW'(q_cnt - CNTW'(1))] = newlim;
    end
    if (pair_v && q_cnt != '0 && (pidx + LW'(1)) == n_lim[0])
      pop = 1'b1;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        n_bank[i] = n_bank[i+1];
        n_pcol[i] = n_pcol[i+1];
        n_ap[i]   = n_ap[i+1];
        n_lim[i]  = n_lim[i+1];
      end
      n_cnt = q_cnt - CNTW'(1);
    end
    if (push && n_cnt != CNTW'(DEPTH)) begin
      n_bank[IW'(n_cnt)] = cmd_bank;
      n_pcol[IW'(n_cnt)] = cmd_pcol;
      n_ap[IW'(n_cnt)]   = cmd_ap;
      n_lim[IW'(n_cnt)]  = maxp;
      n_cnt = n_cnt + CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        q_bank[i] <= '0;
        q_pcol[i] <= '0;
        q_ap[i]   <= 1'b0;
        q_lim[i]  <= '0;
      end
      q_cnt     <= '0;
      pidx      <= '0;
      elapsed   <= '0;
      pre_valid <= 1'b0;
      pre_bank  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        q_bank[i] <= n_bank[i];
        q_pcol[i] <= n_pcol[i];
        q_ap[i]   <= n_ap[i];
        q_lim[i]  <= n_lim[i];
      end
      q_cnt <= n_cnt;
      if (pop)
        pidx <= '0;
      else if (pair_v && q_cnt != '0)
        pidx <= pidx + LW'(1);
      if (ck_rise) begin
        if (push)
          elapsed <= '0;
        else if (elapsed < maxp)
          elapsed <= elapsed + LW'(1);
      end
      pre_valid <= pop && q_ap[0];
      pre_bank  <= q_bank[0];
    end
  end

endmodule

// File: rtl/ddrw_pair_array.sv
module ddrw_pair_array #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [2*DW-1:0] wdata,
  input  logic [1:0]      wkeep,
  input  logic [AW-1:0]   raddr,
  output logic [2*DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] rd_q;

    initial begin
      for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
      if (we && wkeep[g])
        mem[waddr] <= wdata[g*DW +: DW];
    end

    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else     rd_q <= mem[raddr];
    end

    assign rdata[g*DW +: DW] = rd_q;
  end

endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture #(
  parameter int BANKS = 4,
  parameter int COLS  = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int MAXP  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   ck_rise,
  input  logic                                   cmd_wr,
  input  logic [$clog2(BANKS)-1:0]               cmd_bank,
  input  logic [$clog2(COLS)-2:0]                cmd_pcol,
  input  logic                                   cmd_ap,
  input  logic [1:0]                             bl_sel,
  input  logic                                   dqs,
  input  logic [DW-1:0]                          dq,
  input  logic                                   dm,
  input  logic [$clog2(BANKS)+$clog2(COLS)-2:0]  dbg_addr,
  output logic [2*DW-1:0]                        dbg_data,
  output logic                                   pre_valid,
  output logic [$clog2(BANKS)-1:0]               pre_bank
);

  localparam int BW   = $clog2(BANKS);
  localparam int PW   = $clog2(COLS) - 1;
  localparam int AW   = BW + PW;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic            active;
  logic            pair_v;
  logic [2*DW-1:0] pair_data;
  logic [1:0]      pair_keep;
  logic [AW-1:0]   waddr;
  logic [CNTW-1:0] q_cnt;

  ddrw_strobe_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .dqs(dqs), .dq(dq), .dm(dm), .active(active),
    .pair_v(pair_v), .pair_data(pair_data), .pair_keep(pair_keep)
  );

  ddrw_cmd_queue #(.BW(BW), .PW(PW), .DEPTH(DEPTH), .MAXP(MAXP)) u_q (
    .clk(clk), .rst(rst), .ck_rise(ck_rise), .cmd_wr(cmd_wr),
    .cmd_bank(cmd_bank), .cmd_pcol(cmd_pcol), .cmd_ap(cmd_ap), .bl_sel(bl_sel),
    .pair_v(pair_v), .active(active), .waddr(waddr), .q_cnt(q_cnt),
    .pre_valid(pre_valid), .pre_bank(pre_bank)
  );

  ddrw_pair_array #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(pair_v), .waddr(waddr), .wdata(pair_data),
    .wkeep(pair_keep), .raddr(dbg_addr), .rdata(dbg_data)
  );

endmodule

// File: rtl/ddrw_wr_checker.sv
module ddrw_wr_checker #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ck_rise,
  input logic                       cmd_wr,
  input logic [$clog2(DEPTH+1)-1:0] q_cnt,
  input logic                       pair_v,
  input logic                       active,
  input logic                       pre_valid
);

  localparam int CNTW = $clog2(DEPTH + 1);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (ck_rise && cmd_wr) |-> (q_cnt < CNTW'(DEPTH)));

  a_r7_pair_needs_burst: assert property (@(posedge clk) disable iff (rst)
    pair_v |-> active);

  a_r2_pair_spacing: assert property (@(posedge clk) disable iff (rst)
    pair_v |=> !pair_v);

  a_r8_pre_after_pair: assert property (@(posedge clk) disable iff (rst)
    pre_valid |-> $past(pair_v));

  a_r8_pre_single: assert property (@(posedge clk) disable iff (rst)
    pre_valid |=> !pre_valid);

endmodule

bind ddr_wr_capture ddrw_wr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ck_rise(ck_rise), .cmd_wr(cmd_wr), .q_cnt(q_cnt),
  .pair_v(pair_v), .active(active), .pre_valid(pre_valid)
);

// File: tb/ddr_wr_capture_tb_top.sv
module ddr_wr_capture_tb_top;
  localparam int NS = 96;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, ck_rise, cmd_wr, cmd_ap, dqs, dm;
  logic [1:0] cmd_bank, bl_sel, pre_bank;
  logic [2:0] cmd_pcol;
  logic [7:0] dq;
  logic [4:0] dbg_addr;
  logic [15:0] dbg_data;
  logic       pre_valid;

  ddr_wr_capture dut_i (
    .clk(clk), .rst(rst), .ck_rise(ck_rise), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
    .cmd_pcol(cmd_pcol), .cmd_ap(cmd_ap), .bl_sel(bl_sel), .dqs(dqs), .dq(dq),
    .dm(dm), .dbg_addr(dbg_addr), .dbg_data(dbg_data), .pre_valid(pre_valid),
    .pre_bank(pre_bank)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] ref_mem [64];
  bit         dqs_a [NS];
  logic [7:0] dq_a  [NS];
  bit         dm_a  [NS];
  bit         ck_a  [NS];
  bit         cw_a  [NS];
  logic [1:0] cb_a  [NS];
  logic [2:0] cp_a  [NS];
  bit         ca_a  [NS];
  int sc_n;
  int sc_cyc [6];
  int sc_bank [6];
  int sc_pcol [6];
  bit sc_ap [6];
  int exp_pre [$];
  int got_pre [$];

  always @(negedge clk) if (!rst && pre_valid) got_pre.push_back(int'(pre_bank));

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural schedule: strobe/data timeline per sample, and reference array updates.
  task automatic build(int blc, int tq, bit mask_en, bit junk, int seed);
    int bl, np, lastend;
    bl = (blc == 0) ? 2 : (blc == 1) ? 4 : 8;
    np = bl / 2;
    lastend = 0;
    for (int t = 0; t < NS; t++) begin
      dqs_a[t] = 0; dq_a[t] = 8'h00; dm_a[t] = 0; ck_a[t] = (t % 4 == 0);
      cw_a[t] = 0; cb_a[t] = 0; cp_a[t] = 0; ca_a[t] = 0;
    end
    for (int k = 0; k < sc_n; k++) begin
      int s, pairs, start;
      s = 4 + 4 * sc_cyc[k];
      cw_a[s] = 1; cb_a[s] = 2'(sc_bank[k]); cp_a[s] = 3'(sc_pcol[k]); ca_a[s] = sc_ap[k];
      pairs = np;
      if (k < sc_n - 1 && sc_cyc[k+1] - sc_cyc[k] < np) pairs = sc_cyc[k+1] - sc_cyc[k];
      start = s + tq;
      for (int b = 0; b < 2 * pairs; b++) begin
        logic [7:0] d;
        bit m;
        int col;
        d = 8'((seed * 29 + k * 16 + b * 7 + 3) & 255);
        m = mask_en && ((k + b + seed) % 3 == 0);
        for (int u = 0; u < 2; u++) begin
          dqs_a[start + 2*b + u] = (b % 2 == 0);
          dq_a[start + 2*b + u]  = d;
          dm_a[start + 2*b + u]  = m;
        end
        col = ((sc_pcol[k] * 2) & ~(bl - 1)) | ((sc_pcol[k] * 2 + b) & (bl - 1));
        if (!m) ref_mem[sc_bank[k] * 16 + col] = d;
      end
      if (sc_ap[k]) exp_pre.push_back(sc_bank[k]);
      lastend = start + 4 * pairs;
    end
    if (junk) begin
      // R10: request outside a memory-clock edge; R7: strobe with no burst outstanding
      cw_a[lastend + 2] = 1; cb_a[lastend + 2] = 2'd3; ca_a[lastend + 2] = 1;
      for (int b = 0; b < 4; b++)
        for (int u = 0; u < 2; u++) begin
          dqs_a[lastend + 6 + 2*b + u] = (b % 2 == 0);
          dq_a[lastend + 6 + 2*b + u]  = 8'hEE;
        end
    end
  endtask

  task automatic play();
    for (int t = 0; t < NS; t++) begin
      @(negedge clk);
      ck_rise = ck_a[t]; cmd_wr = cw_a[t]; cmd_bank = cb_a[t]; cmd_pcol = cp_a[t];
      cmd_ap = ca_a[t]; dqs = dqs_a[t]; dq = dq_a[t]; dm = dm_a[t];
    end
    @(negedge clk);
    ck_rise = 0; cmd_wr = 0; dqs = 0; dq = 0; dm = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic verify(string tag);
    chk({tag, " R8"}, "precharge pulse count", got_pre.size(), exp_pre.size());
    for (int i = 0; i < exp_pre.size() && i < got_pre.size(); i++)
      chk({tag, " R8"}, "precharge bank", got_pre[i], exp_pre[i]);
    got_pre.delete();
    exp_pre.delete();
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      dbg_addr = 5'(a);
      @(negedge clk); // R11: one clock of read latency
      chk({tag, " R3 R11"}, $sformatf("word %0d", a), int'(dbg_data),
          int'({ref_mem[(a >> 3) * 16 + (a & 7) * 2 + 1], ref_mem[(a >> 3) * 16 + (a & 7) * 2]}));
    end
  endtask

  task automatic set_cmd(int k, int cyc, int bank, int pcol, bit ap);
    sc_cyc[k] = cyc; sc_bank[k] = bank; sc_pcol[k] = pcol; sc_ap[k] = ap;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;
    rst = 1; ck_rise = 0; cmd_wr = 0; cmd_bank = 0; cmd_pcol = 0; cmd_ap = 0;
    bl_sel = 0; dqs = 0; dq = 0; dm = 0; dbg_addr = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9", "pre_valid after reset", int'(pre_valid), 0);
    chk("R9", "dbg_data after reset", int'(dbg_data), 0);

    // S1: BL4, nominal delay, single burst, then ignored activity (R1 R2 R7 R10)
    bl_sel = 2'd1; sc_n = 1;
    set_cmd(0, 0, 0, 0, 0);
    build(1, 4, 0, 1, 1); play(); verify("R1 R2 R7 R10");

    // S2: BL8, early strobe, two concatenated full bursts with wrap (R2 R4 R8)
    bl_sel = 2'd2; sc_n = 2;
    set_cmd(0, 0, 1, 2, 1); set_cmd(1, 4, 2, 5, 0);
    build(2, 3, 0, 0, 2); play(); verify("R2 R4");

    // S3: BL8 via code 3, late strobe, truncation to 2 then 1 pair (R6 R1)
    bl_sel = 2'd3; sc_n = 3;
    set_cmd(0, 0, 3, 0, 1); set_cmd(1, 2, 0, 4, 1); set_cmd(2, 3, 1, 7, 0);
    build(3, 5, 0, 0, 3); play(); verify("R6 R1");

    // S4: BL2, masks, non-consecutive and consecutive writes (R5 R1)
    bl_sel = 2'd0; sc_n = 3;
    set_cmd(0, 0, 2, 1, 0); set_cmd(1, 3, 3, 6, 0); set_cmd(2, 4, 2, 3, 1);
    build(0, 4, 1, 0, 4); play(); verify("R5 R1");

    // S5: BL4, early strobe, back-to-back writes every cycle with masks (R6 R10 R5)
    bl_sel = 2'd1; sc_n = 4;
    set_cmd(0, 0, 0, 5, 1); set_cmd(1, 1, 1, 3, 0); set_cmd(2, 2, 3, 7, 1); set_cmd(3, 3, 2, 0, 1);
    build(1, 3, 1, 0, 5); play(); verify("R6 R10 R5");

    // S6: BL8 truncated at late strobe with a masked even beat (R6 R2 R5)
    bl_sel = 2'd2; sc_n = 2;
    set_cmd(0, 0, 1, 6, 0); set_cmd(1, 1, 1, 1, 1);
    build(2, 5, 1, 0, 6); play(); verify("R6 R2 R5");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule